// File: doc/BRIEF.md
# Packet Timestamp Capture Latch (receive and transmit pair)

This block keeps one timestamp for each packet direction. An outside event filter raises a capture strobe with a packet sequence identifier. If that direction's latch is enabled and empty, the block copies the live 64-bit time value and the identifier into its registers in one clock cycle. It then marks the latch as full.

Software reads a status word, which holds a full flag and the stored identifier, and two 32-bit timestamp words. A timestamp read while the flag is clear is not to be trusted. Software empties the latch by writing the status word with the flag bit set.

The receive slot and the transmit slot are separate and do not affect each other. The capture strobe is a valid/ready input. `*_cap_ready` is high only when a strobe in that cycle would be taken. The filter is never stalled: a strobe raised while ready is low is dropped for good, so the first timestamp taken is the one kept.

Top module: `ts_capture_pair`

## Requirements
- R1: After reset, every readable word reads 0 and both ready outputs are low.
- R2: A strobe taken in cycle N shows on the register reads after the clock edge of cycle N:
  - the status word has bit 16 set and the strobe's identifier in bits [15:0];
  - the low timestamp word holds bits [31:0] of the time value sampled in cycle N;
  - the high timestamp word holds bits [63:32] of that time value.
- R3: While bit 16 of a status word is set, further strobes to that slot are dropped. The status and timestamp words do not change.
- R4: Writing the status word with bit 16 set clears bit 16 and leaves the identifier field unchanged. Writing it with bit 16 clear has no effect.
- R5: Writing 0 to the enable word disables capture, and strobes are then dropped. Writing any nonzero value enables capture. The enable word reads back as 1 or 0 in bit 0.
- R6: When a strobe and a re-arm write to the same slot fall in the same cycle, the re-arm wins. The strobe is dropped, and bit 16 reads 0 afterwards.
- R7: The receive slot and the transmit slot are independent. Strobes, enables and re-arms of one slot leave every word of the other slot unchanged.
- R8: Both timestamp words are read-only, and writes to them are ignored.
- R9: `*_cap_ready` is high exactly when the slot is enabled, its bit 16 is clear, and no re-arm write to it is present in that cycle.
- R10: Register map. `reg_addr[2]` selects the slot: 0 is receive, 1 is transmit. `reg_addr[1:0]` selects the word within the slot: 0 status, 1 low timestamp, 2 high timestamp, 3 enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | 64 | Live time value |
| rx_cap_valid | input | 1 | Receive capture strobe |
| rx_cap_seq | input | 16 | Receive packet identifier |
| rx_cap_ready | output | 1 | Receive slot will take a strobe this cycle |
| tx_cap_valid | input | 1 | Transmit capture strobe |
| tx_cap_seq | input | 16 | Transmit packet identifier |
| tx_cap_ready | output | 1 | Transmit slot will take a strobe this cycle |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address, shared by read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |

## Verification
The bench sweeps 64 identifiers through a full capture, hold and re-arm cycle, using a time value computed from each index.

It targets these failure modes:
- A latch that overwrites while full would show the second identifier and time after a repeat strobe.
- A re-arm that also clears the identifier, or that reacts to a write with bit 16 clear, shows up on the status read.
- Giving the same-cycle collision to the strobe would leave bit 16 set.
- Shared state between the slots would make one slot's captures, enables or re-arms appear on the other slot's words.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned FLAG_BIT  = 16;
  localparam int unsigned NUM_DIR   = 2;
  localparam int unsigned WORDS_PER = 4;
  typedef enum logic [1:0] {
    W_STAT = 2'd0,
    W_TLO  = 2'd1,
    W_THI  = 2'd2,
    W_ENA  = 2'd3
  } word_sel_e;
endpackage

// File: rtl/ts_cap_slot.sv
module ts_cap_slot
  import ts_cap_pkg::*;
#(
  parameter int unsigned SEQ_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_valid,
  input  logic [SEQ_W-1:0]  cap_seq,
  output logic              cap_ready,
  input  logic [2*WORD_W-1:0] time_now,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] stat_word,
  output logic [WORD_W-1:0] tlo_word,
  output logic [WORD_W-1:0] thi_word,
  output logic [WORD_W-1:0] ena_word
);
  logic                 held_q;
  logic                 en_q;
  logic [SEQ_W-1:0]     seq_q;
  logic [2*WORD_W-1:0]  ts_q;
  logic                 rearm;
  logic                 cap_fire;

  assign rearm     = wr_en && (wr_sel == W_STAT) && wr_data[FLAG_BIT];
  assign cap_ready = en_q && !held_q && !rearm;
  assign cap_fire  = cap_valid && cap_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      en_q   <= 1'b0;
      seq_q  <= '0;
      ts_q   <= '0;
    end else begin
      if (wr_en && (wr_sel == W_ENA)) en_q <= |wr_data;
      if (rearm) begin
        held_q <= 1'b0;
      end else if (cap_fire) begin
        held_q <= 1'b1;
        seq_q  <= cap_seq;
        ts_q   <= time_now;
      end
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[SEQ_W-1:0] = seq_q;
    stat_word[FLAG_BIT]  = held_q;
    ena_word = '0;
    ena_word[0] = en_q;
  end
  assign tlo_word = ts_q[WORD_W-1:0];
  assign thi_word = ts_q[2*WORD_W-1:WORD_W];

  p_capture_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid && cap_ready |=> held_q && seq_q == $past(cap_seq));
  p_held_keeps_time_r3: assert property (@(posedge clk) disable iff (!rst_n)
    held_q |=> $stable(ts_q) && $stable(seq_q));
  p_rearm_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> !held_q);
  p_disabled_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q && !held_q |=> !held_q);
  p_rearm_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rearm && cap_valid |=> !held_q && $stable(ts_q));
endmodule

// File: rtl/ts_reg_rdmux.sv
module ts_reg_rdmux
  import ts_cap_pkg::*;
#(
  parameter int unsigned N_WORDS = NUM_DIR * WORDS_PER
) (
  input  logic [N_WORDS*WORD_W-1:0]  words,
  input  logic [$clog2(N_WORDS)-1:0] sel,
  output logic [WORD_W-1:0]          rdata
);
  assign rdata = words[sel*WORD_W +: WORD_W];
endmodule

// File: rtl/ts_capture_pair.sv
module ts_capture_pair
  import ts_cap_pkg::*;
#(
  parameter int unsigned SEQ_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [63:0]         time_now,
  input  logic                rx_cap_valid,
  input  logic [SEQ_W-1:0]    rx_cap_seq,
  output logic                rx_cap_ready,
  input  logic                tx_cap_valid,
  input  logic [SEQ_W-1:0]    tx_cap_seq,
  output logic                tx_cap_ready,
  input  logic                reg_wr_en,
  input  logic [2:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata
);
  localparam int unsigned N_WORDS = NUM_DIR * WORDS_PER;

  logic [NUM_DIR-1:0]   v_arr;
  logic [SEQ_W-1:0]     s_arr [NUM_DIR];
  logic [NUM_DIR-1:0]   r_arr;
  logic [N_WORDS*WORD_W-1:0] all_words;

  assign v_arr    = {tx_cap_valid, rx_cap_valid};
  assign s_arr[0] = rx_cap_seq;
  assign s_arr[1] = tx_cap_seq;
  assign rx_cap_ready = r_arr[0];
  assign tx_cap_ready = r_arr[1];

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    localparam int unsigned B = d * WORDS_PER * WORD_W;
    logic slot_wr;
    assign slot_wr = reg_wr_en && (reg_addr[2] == 1'(d));
    ts_cap_slot #(.SEQ_W(SEQ_W)) i_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_valid(v_arr[d]),
      .cap_seq  (s_arr[d]),
      .cap_ready(r_arr[d]),
      .time_now (time_now),
      .wr_en    (slot_wr),
      .wr_sel   (reg_addr[1:0]),
      .wr_data  (reg_wdata),
      .stat_word(all_words[B + 0*WORD_W +: WORD_W]),
      .tlo_word (all_words[B + 1*WORD_W +: WORD_W]),
      .thi_word (all_words[B + 2*WORD_W +: WORD_W]),
      .ena_word (all_words[B + 3*WORD_W +: WORD_W])
    );
  end

  ts_reg_rdmux #(.N_WORDS(N_WORDS)) i_rdmux (
    .words(all_words),
    .sel  (reg_addr),
    .rdata(reg_rdata)
  );

  p_slots_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && reg_addr[2] && !rx_cap_valid |=>
      $stable(all_words[WORDS_PER*WORD_W-1:0]));
endmodule

// File: tb/test_ts_capture_pair.sv
module test_ts_capture_pair;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] time_now = '0;
  logic        rx_cap_valid = 0, tx_cap_valid = 0;
  logic [15:0] rx_cap_seq = '0, tx_cap_seq = '0;
  logic        rx_cap_ready, tx_cap_ready;
  logic        reg_wr_en = 0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  ts_capture_pair i_ts_capture_pair (.*);

  function automatic logic [63:0] tval(int i);
    logic [31:0] a, b;
    a = 32'(i) * 32'h9E3779B9;
    b = ~(32'(i) * 32'h85EBCA6B);
    return {a, b};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(string tag, int dir, int w, logic [31:0] exp);
    reg_addr = 3'(dir*4 + w);
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wr(int dir, int w, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = 3'(dir*4 + w); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic strobe(int dir, logic [15:0] s, logic [63:0] t);
    @(negedge clk);
    time_now = t;
    if (dir == 0) begin rx_cap_valid = 1; rx_cap_seq = s; end
    else begin tx_cap_valid = 1; tx_cap_seq = s; end
    @(negedge clk);
    rx_cap_valid = 0; tx_cap_valid = 0;
    time_now = ~t;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] t;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int d = 0; d < 2; d++)
      for (int w = 0; w < 4; w++) rd("R1 reset word", d, w, 0);
    chk("R1 rx ready", 32'(rx_cap_ready), 0);
    chk("R1 tx ready", 32'(tx_cap_ready), 0);

    strobe(0, 16'h1234, 64'h5);
    rd("R5 disabled strobe dropped", 0, 0, 0);

    wr(0, 3, 7);
    rd("R5 enable reads 1", 0, 3, 1);
    chk("R9 ready when armed", 32'(rx_cap_ready), 1);

    for (int i = 0; i < 64; i++) begin
      logic [15:0] s;
      s = 16'(i * 1031 + 3);
      t = tval(i);
      strobe(0, s, t);
      rd("R2 status", 0, 0, {15'b0, 1'b1, s});
      rd("R2 low word", 0, 1, t[31:0]);
      rd("R2 high word", 0, 2, t[63:32]);
      chk("R9 ready low when full", 32'(rx_cap_ready), 0);
      strobe(0, ~s, ~t);
      rd("R3 status kept", 0, 0, {15'b0, 1'b1, s});
      rd("R3 low kept", 0, 1, t[31:0]);
      wr(0, 0, 32'hFFFE_FFFF);
      rd("R4 write without flag ignored", 0, 0, {15'b0, 1'b1, s});
      wr(0, 0, 32'h0001_0000);
      rd("R4 rearm keeps id", 0, 0, {16'b0, s});
      rd("R7 tx untouched", 1, 0, 0);
    end

    t = tval(200);
    strobe(0, 16'hAAAA, t);
    wr(0, 1, 32'hDEAD_BEEF);
    wr(0, 2, 32'hDEAD_BEEF);
    rd("R8 low read-only", 0, 1, t[31:0]);
    rd("R8 high read-only", 0, 2, t[63:32]);

    // R6: held slot, re-arm and strobe in the same cycle
    @(negedge clk);
    reg_wr_en = 1; reg_addr = 3'd0; reg_wdata = 32'h0001_0000;
    rx_cap_valid = 1; rx_cap_seq = 16'h5555; time_now = 64'h77;
    #1 chk("R9 ready low during rearm", 32'(rx_cap_ready), 0);
    @(negedge clk);
    reg_wr_en = 0; rx_cap_valid = 0;
    rd("R6 rearm wins held", 0, 0, 32'h0000_AAAA);
    // R6: empty slot, collision still drops the strobe
    @(negedge clk);
    reg_wr_en = 1; reg_addr = 3'd0; reg_wdata = 32'h0001_0000;
    rx_cap_valid = 1; rx_cap_seq = 16'h6666; time_now = 64'h88;
    @(negedge clk);
    reg_wr_en = 0; rx_cap_valid = 0;
    rd("R6 rearm wins empty", 0, 0, 32'h0000_AAAA);
    rd("R6 time unchanged", 0, 1, t[31:0]);

    wr(0, 3, 0);
    rd("R5 disable reads 0", 0, 3, 0);
    chk("R9 ready low when disabled", 32'(rx_cap_ready), 0);
    strobe(0, 16'h1111, 64'h99);
    rd("R5 disabled drops", 0, 0, 32'h0000_AAAA);
    wr(0, 3, 32'h0000_0100);
    rd("R5 nonzero enables", 0, 3, 1);

    t = tval(300);
    strobe(0, 16'h0101, t);
    wr(1, 3, 1);
    rd("R7 tx enable alone", 0, 0, 32'h0001_0101);
    strobe(1, 16'h0202, tval(301));
    rd("R10 tx status", 1, 0, 32'h0001_0202);
    rd("R10 tx high", 1, 2, tval(301) >> 32);
    rd("R7 rx kept", 0, 1, t[31:0]);
    wr(1, 0, 32'h0001_0000);
    rd("R7 tx rearmed", 1, 0, 32'h0000_0202);
    rd("R7 rx still full", 0, 0, 32'h0001_0101);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule